// File: doc/BRIEF.md
# Pixel Colour Resolver with Blink

This block sits at the end of an on-screen display pixel pipeline. For every display pixel it receives the pixel's class from the glyph rasteriser (foreground, border, character background or page background), the 12-bit character word of the character cell, the two per-row enables and the page-wide control and colour settings. From these it picks one 3-bit RGB colour and drives a fast-blank strobe for the external RGB switch. It also drives a character-activity strobe and a flag that tells the mixer to pass live video through instead of the generated colour.

A blink timer inside the block counts field ticks. The blink period depends on the field rate and on a fast/slow select. A duty field sets what fraction of each period the blinking foreground stays visible, and the visible part comes at the start of the period. In mixed mode the page background is always live video. In full-page mode the page background is either a solid screen colour or live video, chosen by a separate select.

Top module: `osd_pixel_colour`

## Requirements
- R1: Pixel class encoding: 0 page background, 1 character background, 2 border, 3 foreground. A displayed foreground pixel outputs the character colour `char_word[10:8]` (R,G,B with 000 black, 001 blue, 010 green, 011 cyan, 100 red, 101 magenta, 110 yellow, 111 white) with `fblank`=1 and `char_act`=1. All outputs are registered and appear one clock after the inputs.
- R2: A border pixel shows `brd_col` only when `row_border`=1. With `row_border`=0 it is treated as a character-background pixel.
- R3: A character-background pixel shows `cbg_col` when `char_word[11]`=1 and `bg_kill`=0. Otherwise it is treated as a page-background pixel.
- R4: With `collapse`=1, border and character background take the character colour `char_word[10:8]`. The screen colour `scr_col` is unaffected.
- R5: A page-background pixel gives `video_sel`=1, `fblank`=0 and `rgb`=000 in mixed mode (`full_page`=0) and in full-page mode with `fp_video`=1. In full-page mode with `fp_video`=0 it gives `scr_col` with `fblank`=1.
- R6: With `disp_on`=0 or `row_show`=0, every class is shown as page background and `char_act` stays 0.
- R7: The blink timer advances by one on each `field_tick` and wraps to 0 after reaching P-1. P is 50 when `std_50hz`=1 and 60 otherwise, halved when `blink_fast`=1. After reset the count is 0.
- R8: `blink_duty` 00 disables blink. For 01, 10 and 11, a character with `char_word[7]`=1 is visible while 4·count < k·P, with k = 3, 2 or 1 respectively. Characters with `char_word[7]`=0 never blink.
- R9: In the off phase, a blinking foreground pixel shows the character background colour when its background is enabled (R3). Otherwise it is shown as page background.
- R10: `char_act` is 1 only on displayed foreground pixels, and `fblank` equals the inverse of `video_sel`.
- R11: During reset the outputs are `rgb`=000, `fblank`=0, `char_act`=0 and `video_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_tick | input | 1 | One-cycle pulse per video field |
| pix_class | input | 2 | Pixel class (R1 encoding) |
| char_word | input | 12 | Background enable, colour, blink enable, glyph code |
| row_show | input | 1 | Row display enable |
| row_border | input | 1 | Row border enable |
| disp_on | input | 1 | Global display enable |
| full_page | input | 1 | 1 full-page mode, 0 mixed mode |
| fp_video | input | 1 | Full-page background is live video |
| bg_kill | input | 1 | Suppress all character backgrounds |
| collapse | input | 1 | Border and background take character colour |
| blink_fast | input | 1 | Halve the blink period |
| blink_duty | input | 2 | Blink duty select |
| std_50hz | input | 1 | 1 for 50 fields/s, 0 for 60 |
| scr_col | input | 3 | Screen colour |
| brd_col | input | 3 | Border colour |
| cbg_col | input | 3 | Character background colour |
| rgb | output | 3 | Resolved colour |
| fblank | output | 1 | Fast blank to the RGB switch |
| char_act | output | 1 | Foreground activity |
| video_sel | output | 1 | Pass live video |

## Verification
All four outputs come from one register stage, so every result is due on the first rising edge after the pixel inputs are applied. The blink phase used for that pixel is the timer count held before that same edge, and a `field_tick` applied together with the pixel moves the count only for the following pixel. The bench drives inputs on the falling edge and computes the expected values from its own field counter before stepping that counter. It compares on the next falling edge, half a period after the register updates. Long tick-only runs on one blinking glyph walk the visible and hidden windows across the wrap.

// File: rtl/osd_pixel_colour.sv
module osd_pixel_colour #(
  parameter int FIELDS_50 = 50,
  parameter int FIELDS_60 = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       field_tick,
  input  logic [1:0] pix_class,
  input  logic [11:0] char_word,
  input  logic       row_show,
  input  logic       row_border,
  input  logic       disp_on,
  input  logic       full_page,
  input  logic       fp_video,
  input  logic       bg_kill,
  input  logic       collapse,
  input  logic       blink_fast,
  input  logic [1:0] blink_duty,
  input  logic       std_50hz,
  input  logic [2:0] scr_col,
  input  logic [2:0] brd_col,
  input  logic [2:0] cbg_col,
  output logic [2:0] rgb,
  output logic       fblank,
  output logic       char_act,
  output logic       video_sel
);
  localparam int CW = $clog2(FIELDS_60 + 1);
  localparam logic [1:0] PG = 2'd0, CB = 2'd1, BD = 2'd2, FG = 2'd3;

  logic [CW-1:0] fcnt, period, base;
  logic [CW+1:0] lim;
  logic [2:0]    k;
  logic          phase_on, bg_en, shown;
  logic [1:0]    cls;
  logic [2:0]    ccol, n_rgb;
  logic          n_fb, n_act, n_vid;

  assign base   = std_50hz ? CW'(FIELDS_50) : CW'(FIELDS_60);
  assign period = blink_fast ? (base >> 1) : base;
  assign k      = 3'd4 - {1'b0, blink_duty};
  assign lim    = (CW+2)'(period) * (CW+2)'(k);
  assign phase_on = (blink_duty == 2'd0) || ({fcnt, 2'b00} < lim);

  assign shown = disp_on & row_show;
  assign bg_en = char_word[11] & ~bg_kill;
  assign ccol  = char_word[10:8];

  always_comb begin
    cls = shown ? pix_class : PG;
    if (cls == FG && char_word[7] && !phase_on) cls = bg_en ? CB : PG;
    if (cls == BD && !row_border) cls = CB;
    if (cls == CB && !bg_en) cls = PG;
    n_rgb = 3'd0;
    n_fb  = 1'b1;
    n_act = 1'b0;
    n_vid = 1'b0;
    case (cls)
      FG: begin n_rgb = ccol; n_act = 1'b1; end
      BD: n_rgb = collapse ? ccol : brd_col;
      CB: n_rgb = collapse ? ccol : cbg_col;
      default: begin
        if (full_page && !fp_video) n_rgb = scr_col;
        else begin n_fb = 1'b0; n_vid = 1'b1; end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt      <= '0;
      rgb       <= 3'd0;
      fblank    <= 1'b0;
      char_act  <= 1'b0;
      video_sel <= 1'b1;
    end else begin
      if (field_tick) fcnt <= (fcnt >= period - CW'(1)) ? '0 : fcnt + CW'(1);
      rgb       <= n_rgb;
      fblank    <= n_fb;
      char_act  <= n_act;
      video_sel <= n_vid;
    end
  end
endmodule

// File: rtl/osd_pixel_colour_chk.sv
module osd_pixel_colour_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pix_class,
  input logic       row_show,
  input logic       disp_on,
  input logic       full_page,
  input logic       fp_video,
  input logic [1:0] blink_duty,
  input logic [2:0] rgb,
  input logic       fblank,
  input logic       char_act,
  input logic       video_sel
);
  assert_act_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    char_act |-> fblank);
  assert_video_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    video_sel |-> (!fblank && rgb == 3'd0));
  assert_text_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_on || !row_show) |=> !char_act);
  assert_mixed_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_page && pix_class == 2'd0) |=> video_sel);
  assert_solid_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full_page && !fp_video) |=> !video_sel);
  assert_no_blink_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (blink_duty == 2'd0 && disp_on && row_show && pix_class == 2'd3) |=> char_act);
endmodule

bind osd_pixel_colour osd_pixel_colour_chk chk (.*);

// File: tb/osd_pixel_colour_test.sv
module osd_pixel_colour_test;
  logic clk = 0, rst_n = 0, field_tick = 0;
  logic [1:0] pix_class = 0, blink_duty = 0;
  logic [11:0] char_word = 0;
  logic row_show = 0, row_border = 0, disp_on = 0, full_page = 0, fp_video = 0;
  logic bg_kill = 0, collapse = 0, blink_fast = 0, std_50hz = 0;
  logic [2:0] scr_col = 0, brd_col = 0, cbg_col = 0;
  logic [2:0] rgb;
  logic fblank, char_act, video_sel;

  int checks = 0, fails = 0, mcnt = 0;
  logic [2:0] e_rgb;
  logic e_fb, e_act, e_vid;
  string tag;

  always #10 clk = ~clk;

  osd_pixel_colour uut (.*);

  task automatic calc();
    int p, cls;
    bit on, bgen;
    p = std_50hz ? 50 : 60;
    if (blink_fast) p = p / 2;
    on = (blink_duty == 0) || (4 * mcnt < (4 - blink_duty) * p);
    bgen = char_word[11] && !bg_kill;
    cls = pix_class;
    tag = "R1";
    if (!disp_on || !row_show) begin cls = 0; tag = "R6"; end
    if (cls == 3 && char_word[7] && !on) begin cls = bgen ? 1 : 0; tag = "R9"; end
    if (cls == 2 && !row_border) begin cls = 1; tag = "R2"; end
    if (cls == 1 && !bgen) begin cls = 0; tag = "R3"; end
    e_fb = 1; e_act = 0; e_vid = 0; e_rgb = 0;
    if (cls == 3) begin e_rgb = char_word[10:8]; e_act = 1; end
    else if (cls == 2) begin e_rgb = collapse ? char_word[10:8] : brd_col; if (tag == "R1") tag = collapse ? "R4" : "R2"; end
    else if (cls == 1) begin e_rgb = collapse ? char_word[10:8] : cbg_col; if (tag == "R1") tag = collapse ? "R4" : "R3"; end
    else begin
      if (tag == "R1") tag = "R5";
      if (full_page && !fp_video) e_rgb = scr_col;
      else begin e_fb = 0; e_vid = 1; end
    end
  endtask

  task automatic compare(string t);
    checks++;
    if ({rgb, fblank, char_act, video_sel} !== {e_rgb, e_fb, e_act, e_vid}) begin
      fails++;
      $display("FAIL %s: rgb/fb/act/vid got %b/%b/%b/%b expected %b/%b/%b/%b",
               t, rgb, fblank, char_act, video_sel, e_rgb, e_fb, e_act, e_vid);
    end
  endtask

  task automatic step(string force_tag = "");
    int p;
    calc();
    if (force_tag != "") tag = force_tag;
    @(posedge clk);
    p = std_50hz ? 50 : 60;
    if (blink_fast) p = p / 2;
    if (field_tick) mcnt = (mcnt >= p - 1) ? 0 : mcnt + 1;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    int seed;
    seed = $urandom(7);
    repeat (3) @(posedge clk);
    @(negedge clk);
    e_rgb = 0; e_fb = 0; e_act = 0; e_vid = 1;
    compare("R11");
    rst_n = 1;

    // directed: foreground, mixed page, full page
    disp_on = 1; row_show = 1; pix_class = 3; char_word = 12'h5A3; step("R1");
    pix_class = 0; step("R5");
    full_page = 1; scr_col = 3'd6; step("R5");
    fp_video = 1; step("R5");
    fp_video = 0; pix_class = 2; row_border = 0; char_word = 12'h800; cbg_col = 3'd2; step("R2");
    bg_kill = 1; step("R3");
    bg_kill = 0; collapse = 1; char_word = 12'hB00; row_border = 1; step("R4");
    collapse = 0; disp_on = 0; pix_class = 3; step("R6");
    disp_on = 1; row_show = 0; step("R6");
    row_show = 1;

    // directed blink walk: 50 Hz slow, half duty, then 60 Hz fast, quarter duty
    full_page = 0; pix_class = 3; char_word = 12'h780; std_50hz = 1; blink_duty = 2'b10;
    field_tick = 1;
    for (int i = 0; i < 120; i++) step(i < 60 ? "R8" : "R7");
    char_word = 12'hF80; blink_duty = 2'b11; blink_fast = 1; std_50hz = 0;
    for (int i = 0; i < 70; i++) step("R9");
    field_tick = 0;

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      field_tick = ($urandom % 3) == 0;
      pix_class = 2'($urandom);
      char_word = 12'($urandom);
      row_show = ($urandom % 8) != 0;
      row_border = 1'($urandom);
      disp_on = ($urandom % 8) != 0;
      full_page = 1'($urandom);
      fp_video = 1'($urandom);
      bg_kill = ($urandom % 4) == 0;
      collapse = ($urandom % 4) == 0;
      if (($urandom % 64) == 0) begin
        blink_fast = 1'($urandom); blink_duty = 2'($urandom); std_50hz = 1'($urandom);
      end
      scr_col = 3'($urandom); brd_col = 3'($urandom); cbg_col = 3'($urandom);
      step();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule